// File: doc/BRIEF.md
# Load/Store Port Memory Adapter

This block serves a single processor load/store port and backs it with a small on-chip memory built from 64-bit words. The requester opens an operation by raising a load or store request together with a valid address and an access length of 1, 2, 4 or 8 bytes. The adapter accepts the address, raises an address-accepted flag, and then either takes one store-data pulse or returns load data. Accesses are little-endian and byte-granular inside a memory word. A store can be marked as a block-zero request. The adapter then ignores its data and clears every word of the aligned block that holds the address, one word per cycle.

Accesses that are not naturally aligned to their length, that carry an illegal length, or that fall outside the memory end with the exception flag instead of a data-valid flag, and they never write memory. A privilege bit travels with each request and does not change behaviour.

Control is a six-state machine.
- `S_IDLE`: not busy. An accepted request moves it to `S_LD_READ` for a load or `S_ST_WAIT` for a store.
- `S_ST_WAIT`: waits for the store-data pulse. On the pulse it moves to `S_ZERO` for an in-range block-zero request and to `S_DONE` otherwise.
- `S_ZERO`: counts through the block and moves to `S_DONE` after the last word.
- `S_DONE`: lasts one cycle and then returns to `S_IDLE`.
- `S_LD_READ`: captures the aligned load result and moves to `S_LD_RESP`.
- `S_LD_RESP`: holds the result until the requester drops its load request or its address-valid flag, then returns to `S_IDLE`.

Top module: `lsport_mem_adapter`

## Requirements
- R1: After reset, busy_o, addr_ack_o, ld_vld_o and exc_o are all 0.
- R2: A request is accepted only in idle (busy_o low), with addr_vld_i high and exactly one of req_ld_i and req_st_i high. addr_ack_o rises one edge after acceptance and is only ever high while busy_o is high. When both request flags are high, busy_o stays low.
- R3: A store of length L at byte address A writes bytes A to A+L-1 with st_data_i bits [8L-1:0], the lowest byte at the lowest address. The store takes effect on the edge where st_vld_i is high after acceptance. All other bytes keep their value.
- R4: ld_vld_o rises two edges after a load is accepted. ld_data_o then holds the L bytes at A, with the byte at A in bits [7:0], and zeros above bit 8L-1. Once the requester drops req_ld_i or addr_vld_i, busy_o is low after the next edge.
- R5: exc_o is raised for three kinds of access: one whose address is not a multiple of its length, one whose length is not 1, 2, 4 or 8, and one whose word index (address bits above bit 2) is not below the memory depth. Such an access writes nothing. A failing load raises exc_o in place of ld_vld_o. A failing store raises exc_o for one cycle after its data pulse.
- R6: A store with zero_blk_i high ignores st_data_i, len_i and the low address bits. It writes zero to all BLOCK_WORDS words of the aligned block that contains the address, one word per cycle after the data pulse. Only the range check of R5 applies to it.
- R7: Request inputs are ignored while busy_o is high, and st_vld_i is ignored outside the wait for store data.
- R8: priv_i has no effect on any result.
- R9: ld_vld_o and exc_o are never high together, and ld_data_o is stable while ld_vld_o stays high.
- R10: Two 2-byte stores to adjacent addresses followed by a 4-byte load from the lower address return the first value in bits [15:0] and the second in bits [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_ld_i | input | 1 | Load request |
| req_st_i | input | 1 | Store request |
| zero_blk_i | input | 1 | Store is a block-zero request |
| priv_i | input | 1 | Privilege bit (1 virtual, 0 real), carried only |
| len_i | input | 4 | Access length in bytes: 1, 2, 4 or 8 |
| addr_i | input | ADDR_W | Byte address |
| addr_vld_i | input | 1 | Address valid |
| st_data_i | input | 64 | Store data, LSB-aligned |
| st_vld_i | input | 1 | One-cycle store data valid pulse |
| busy_o | output | 1 | Operation in progress |
| addr_ack_o | output | 1 | Address accepted |
| ld_data_o | output | 64 | Load data, LSB-aligned, zero-extended |
| ld_vld_o | output | 1 | Load data valid |
| exc_o | output | 1 | Access exception |

## Verification
Acceptance happens on the edge after the inputs are driven, so addr_ack_o is due one edge later. ld_vld_o or exc_o for a load is due two edges after acceptance. A plain store reports exc_o one edge after its data pulse and clears busy_o one edge after that. A block-zero store stays busy for BLOCK_WORDS further edges. The bench drives and samples on the falling edge. It waits for each flag by polling with a bounded count, and checks the cycle at which each one arrives, which catches early or late flags. It then checks memory contents through later loads against a byte-level shadow model.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    localparam int unsigned LANES  = 8;
    localparam int unsigned WORD_W = 64;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ST_WAIT,
        S_ZERO,
        S_DONE,
        S_LD_READ,
        S_LD_RESP
    } lsp_state_e;

    function automatic logic [LANES-1:0] len_to_mask(input logic [3:0] len);
        logic [LANES-1:0] m;
        case (len)
            4'd1:    m = 8'h01;
            4'd2:    m = 8'h03;
            4'd4:    m = 8'h0F;
            4'd8:    m = 8'hFF;
            default: m = 8'h00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lsp_addr_check.sv
module lsp_addr_check #(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DEPTH_WORDS = 64,
    parameter int unsigned BLOCK_WORDS = 4,
    localparam int unsigned IDX_W      = $clog2(DEPTH_WORDS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [3:0]        len_i,
    input  logic              zero_i,
    output logic              err_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [IDX_W-1:0]  blk_o
);
    localparam int unsigned HI_W = ADDR_W - 3;

    logic [HI_W-1:0] word_full;
    logic            in_range;
    logic            misalign;

    assign word_full = addr_i[ADDR_W-1:3];
    assign in_range  = ({1'b0, word_full} < (HI_W+1)'(DEPTH_WORDS));

    always_comb begin
        case (len_i)
            4'd1:    misalign = 1'b0;
            4'd2:    misalign = addr_i[0];
            4'd4:    misalign = |addr_i[1:0];
            4'd8:    misalign = |addr_i[2:0];
            default: misalign = 1'b1;
        endcase
    end

    assign err_o = !in_range || (!zero_i && misalign);
    assign idx_o = word_full[IDX_W-1:0];
    assign blk_o = word_full[IDX_W-1:0] & ~IDX_W'(BLOCK_WORDS - 1);

endmodule

// File: rtl/lsp_lane_map.sv
module lsp_lane_map
    import lsp_pkg::*;
(
    input  logic [2:0]        off_i,
    input  logic [3:0]        len_i,
    input  logic [WORD_W-1:0] st_data_i,
    input  logic [WORD_W-1:0] rd_word_i,
    output logic [LANES-1:0]  wmask_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic [WORD_W-1:0] ld_data_o
);
    logic [LANES-1:0]  len_mask;
    logic [WORD_W-1:0] rd_shift;
    logic [5:0]        bit_off;

    assign len_mask = len_to_mask(len_i);
    assign bit_off  = {off_i, 3'b000};
    assign wmask_o  = len_mask << off_i;
    assign wdata_o  = st_data_i << bit_off;
    assign rd_shift = rd_word_i >> bit_off;

    for (genvar g = 0; g < LANES; g++) begin : g_ld_lane
        assign ld_data_o[8*g +: 8] = len_mask[g] ? rd_shift[8*g +: 8] : 8'h00;
    end

endmodule

// File: rtl/lsp_word_ram.sv
module lsp_word_ram
    import lsp_pkg::*;
#(
    parameter int unsigned DEPTH_WORDS = 64,
    localparam int unsigned IDX_W      = $clog2(DEPTH_WORDS)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [LANES-1:0]  wmask_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [WORD_W-1:0] rdata_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH_WORDS];

        always_ff @(posedge clk) begin
            if (we_i && wmask_i[g]) begin
                lane_mem[widx_i] <= wdata_i[8*g +: 8];
            end
        end

        assign rdata_o[8*g +: 8] = lane_mem[ridx_i];
    end

endmodule

// File: rtl/lsport_mem_adapter.sv
module lsport_mem_adapter
    import lsp_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DEPTH_WORDS = 64,
    parameter int unsigned BLOCK_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_ld_i,
    input  logic              req_st_i,
    input  logic              zero_blk_i,
    input  logic              priv_i,
    input  logic [3:0]        len_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_vld_i,
    input  logic [63:0]       st_data_i,
    input  logic              st_vld_i,
    output logic              busy_o,
    output logic              addr_ack_o,
    output logic [63:0]       ld_data_o,
    output logic              ld_vld_o,
    output logic              exc_o
);
    localparam int unsigned IDX_W = $clog2(DEPTH_WORDS);
    localparam int unsigned CNT_W = $clog2(BLOCK_WORDS) + 1;

    lsp_state_e state_q, state_d;

    logic              zero_q;
    logic              err_q;
    logic [2:0]        off_q;
    logic [3:0]        len_q;
    logic [IDX_W-1:0]  widx_q;
    logic [IDX_W-1:0]  blk_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] ld_data_q;

    logic              accept;
    logic              chk_err;
    logic [IDX_W-1:0]  chk_idx;
    logic [IDX_W-1:0]  chk_blk;
    logic [LANES-1:0]  lane_wmask;
    logic [WORD_W-1:0] lane_wdata;
    logic [WORD_W-1:0] lane_ld;
    logic [WORD_W-1:0] rd_word;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_widx;
    logic [LANES-1:0]  mem_wmask;
    logic [WORD_W-1:0] mem_wdata;
    logic              last_zero;

    logic unused_priv;
    assign unused_priv = priv_i;

    assign accept    = addr_vld_i && (req_ld_i ^ req_st_i);
    assign last_zero = (cnt_q == CNT_W'(BLOCK_WORDS - 1));

    lsp_addr_check #(
        .ADDR_W      (ADDR_W),
        .DEPTH_WORDS (DEPTH_WORDS),
        .BLOCK_WORDS (BLOCK_WORDS)
    ) u_chk (
        .addr_i (addr_i),
        .len_i  (len_i),
        .zero_i (req_st_i && zero_blk_i),
        .err_o  (chk_err),
        .idx_o  (chk_idx),
        .blk_o  (chk_blk)
    );

    lsp_lane_map u_lane (
        .off_i     (off_q),
        .len_i     (len_q),
        .st_data_i (st_data_i),
        .rd_word_i (rd_word),
        .wmask_o   (lane_wmask),
        .wdata_o   (lane_wdata),
        .ld_data_o (lane_ld)
    );

    lsp_word_ram #(
        .DEPTH_WORDS (DEPTH_WORDS)
    ) u_ram (
        .clk     (clk),
        .we_i    (mem_we),
        .widx_i  (mem_widx),
        .wmask_i (mem_wmask),
        .wdata_i (mem_wdata),
        .ridx_i  (widx_q),
        .rdata_o (rd_word)
    );

    // write port steering
    always_comb begin
        mem_we    = 1'b0;
        mem_widx  = widx_q;
        mem_wmask = lane_wmask;
        mem_wdata = lane_wdata;
        if (state_q == S_ZERO) begin
            mem_we    = 1'b1;
            mem_widx  = blk_q + IDX_W'(cnt_q);
            mem_wmask = '1;
            mem_wdata = '0;
        end else if (state_q == S_ST_WAIT) begin
            mem_we = st_vld_i && !err_q && !zero_q;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (accept) state_d = req_ld_i ? S_LD_READ : S_ST_WAIT;
            S_ST_WAIT: if (st_vld_i) state_d = (zero_q && !err_q) ? S_ZERO : S_DONE;
            S_ZERO:    if (last_zero) state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            S_LD_READ: state_d = S_LD_RESP;
            S_LD_RESP: if (!addr_vld_i || !req_ld_i) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            zero_q    <= 1'b0;
            err_q     <= 1'b0;
            off_q     <= '0;
            len_q     <= '0;
            widx_q    <= '0;
            blk_q     <= '0;
            cnt_q     <= '0;
            ld_data_q <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        zero_q <= req_st_i && zero_blk_i;
                        err_q  <= chk_err;
                        off_q  <= addr_i[2:0];
                        len_q  <= len_i;
                        widx_q <= chk_idx;
                        blk_q  <= chk_blk;
                        cnt_q  <= '0;
                    end
                end
                S_ZERO:    cnt_q <= cnt_q + 1'b1;
                S_LD_READ: ld_data_q <= err_q ? '0 : lane_ld;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o     = 1'b1;
        addr_ack_o = 1'b0;
        ld_vld_o   = 1'b0;
        exc_o      = 1'b0;
        ld_data_o  = '0;
        unique case (state_q)
            S_IDLE:    busy_o = 1'b0;
            S_ST_WAIT: addr_ack_o = 1'b1;
            S_ZERO:    ;
            S_DONE:    exc_o = err_q;
            S_LD_READ: addr_ack_o = 1'b1;
            S_LD_RESP: begin
                addr_ack_o = 1'b1;
                ld_vld_o   = !err_q;
                exc_o      = err_q;
                ld_data_o  = err_q ? '0 : ld_data_q;
            end
            default:   ;
        endcase
    end

    AST_ACK_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack_o |-> busy_o); // R2
    AST_MASK_MATCHES_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && state_q == S_ST_WAIT) |-> ($countones(mem_wmask) == int'(len_q))); // R3
    AST_IDLE_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LD_RESP && !addr_vld_i) |=> !busy_o); // R4
    AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !err_q); // R5
    AST_ZERO_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && zero_q) |-> (mem_wdata == '0)); // R6
    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q != S_DONE && state_q != S_LD_RESP) |=> busy_o); // R7
    AST_VLD_EXC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_vld_o && exc_o)); // R9
    AST_LD_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld_o && $past(ld_vld_o)) |-> $stable(ld_data_o)); // R9

endmodule

// File: tb/lsport_mem_adapter_tb_top.sv
module lsport_mem_adapter_tb_top;
    localparam int ADDR_W = 12;
    localparam int DEPTH  = 64;
    localparam int BLK    = 4;
    localparam int NBYTES = DEPTH * 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_ld_i = 0, req_st_i = 0, zero_blk_i = 0, priv_i = 0;
    logic [3:0]  len_i = 0;
    logic [ADDR_W-1:0] addr_i = 0;
    logic        addr_vld_i = 0;
    logic [63:0] st_data_i = 0;
    logic        st_vld_i = 0;
    logic        busy_o, addr_ack_o, ld_vld_o, exc_o;
    logic [63:0] ld_data_o;

    int errors = 0;
    int checks = 0;
    logic [7:0] shadow [NBYTES];

    always #5 clk = ~clk;

    lsport_mem_adapter #(.ADDR_W(ADDR_W), .DEPTH_WORDS(DEPTH), .BLOCK_WORDS(BLK)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_ld_i(req_ld_i), .req_st_i(req_st_i),
        .zero_blk_i(zero_blk_i), .priv_i(priv_i), .len_i(len_i), .addr_i(addr_i),
        .addr_vld_i(addr_vld_i), .st_data_i(st_data_i), .st_vld_i(st_vld_i),
        .busy_o(busy_o), .addr_ack_o(addr_ack_o), .ld_data_o(ld_data_o),
        .ld_vld_o(ld_vld_o), .exc_o(exc_o));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_err(input int addr, input int len, input bit zero);
        if ((addr >> 3) >= DEPTH) return 1;
        if (zero) return 0;
        if (!(len == 1 || len == 2 || len == 4 || len == 8)) return 1;
        return (addr % len) != 0;
    endfunction

    function automatic logic [63:0] exp_load(input int addr, input int len);
        logic [63:0] v = '0;
        for (int k = 0; k < len; k++) v[8*k +: 8] = shadow[addr + k];
        return v;
    endfunction

    task automatic wait_idle();
        for (int n = 0; n < 50 && busy_o; n++) @(negedge clk);
    endtask

    task automatic do_store(input int addr, input int len, input logic [63:0] data,
                            input bit zero, input bit priv);
        bit err = exp_err(addr, len, zero);
        bit saw_exc = 0;
        int n;
        wait_idle();
        req_st_i = 1; addr_vld_i = 1; len_i = 4'(len); addr_i = ADDR_W'(addr);
        zero_blk_i = zero; priv_i = priv;
        @(negedge clk);
        chk(addr_ack_o == 1, "R2 addr_ack one edge after store accept", 64'(addr_ack_o), 1);
        // R7: request inputs changed while busy must be ignored
        req_ld_i = 1; req_st_i = 0; addr_i = ADDR_W'(addr ^ 8);
        st_data_i = data; st_vld_i = 1;
        @(negedge clk);
        st_vld_i = 0; req_ld_i = 0; addr_vld_i = 0; zero_blk_i = 0;
        n = 0;
        while (n < 40) begin
            saw_exc |= exc_o;
            if (!busy_o) break;
            @(negedge clk); n++;
        end
        chk(saw_exc == err, err ? "R5 store exception" : "R3 store no exception",
            64'(saw_exc), 64'(err));
        chk(n == (zero && !err ? BLK + 1 : 1), zero ? "R6 zero fill duration" : "R3 store duration",
            64'(n), 64'(zero && !err ? BLK + 1 : 1));
        if (!err) begin
            if (zero) begin
                int base = ((addr >> 3) & ~(BLK - 1)) * 8;
                for (int k = 0; k < BLK * 8; k++) shadow[base + k] = 8'h00;
            end else begin
                for (int k = 0; k < len; k++) shadow[addr + k] = data[8*k +: 8];
            end
        end
    endtask

    task automatic do_load(input int addr, input int len, input bit priv, input string req);
        bit err = exp_err(addr, len, 0);
        logic [63:0] exp = err ? 64'h0 : exp_load(addr, len);
        logic [63:0] first;
        int n = 0;
        wait_idle();
        req_ld_i = 1; addr_vld_i = 1; len_i = 4'(len); addr_i = ADDR_W'(addr); priv_i = priv;
        @(negedge clk);
        while (!(ld_vld_o || exc_o) && n < 20) begin @(negedge clk); n++; end
        chk(n == 1, "R4 load result two edges after accept", 64'(n), 1);
        chk(exc_o == err, err ? "R5 load exception" : "R4 load no exception", 64'(exc_o), 64'(err));
        chk(ld_vld_o == !err, "R9 load valid vs exception", 64'(ld_vld_o), 64'(!err));
        if (!err) chk(ld_data_o == exp, req, ld_data_o, exp);
        first = ld_data_o;
        @(negedge clk);
        chk(ld_data_o == first && ld_vld_o == !err, "R9 load data held", ld_data_o, first);
        req_ld_i = 0; addr_vld_i = 0;
        @(negedge clk);
        chk(busy_o == 0, "R4 idle after drop", 64'(busy_o), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < NBYTES; k++) shadow[k] = 8'h00;
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && addr_ack_o == 0, "R1 reset busy/ack", {62'd0, busy_o, addr_ack_o}, 0);
        chk(ld_vld_o == 0 && exc_o == 0, "R1 reset valid/exc", {62'd0, ld_vld_o, exc_o}, 0);
        rst_n = 1;
        @(negedge clk);

        // clear memory with block-zero stores at unaligned offsets, garbage data
        for (int b = 0; b < DEPTH / BLK; b++) do_store(b * BLK * 8 + 5, 3, 64'hDEAD_BEEF_CAFE_F00D, 1, 0);
        do_load(8 * 9, 8, 0, "R6 zeroed word");

        // R10: adjacent halfwords then one word
        do_store(16'h40, 2, 64'h1234, 0, 0);
        do_store(16'h42, 2, 64'hABCD, 0, 1);
        do_load(16'h40, 4, 0, "R10 combined little-endian");
        chk(exp_load(16'h40, 4) == 64'hABCD1234, "R10 shadow", exp_load(16'h40, 4), 64'hABCD1234);

        // R3/R4 byte lanes and zero extension
        do_store(16'h50, 8, 64'h8877_6655_4433_2211, 0, 0);
        do_store(16'h53, 1, 64'hFFFF_FFFF_FFFF_FF99, 0, 0);
        do_load(16'h52, 2, 0, "R4 zero-extended halfword");
        do_load(16'h50, 8, 1, "R3 byte merge");

        // R5 error cases leave memory unchanged
        do_store(16'h52, 4, 64'h0BAD_0BAD, 0, 0);
        do_store(16'h50, 3, 64'h0BAD_0BAD, 0, 0);
        do_store(NBYTES, 8, 64'h0BAD_0BAD, 0, 0);
        do_store(NBYTES + 64, 1, 0, 1, 0);
        do_load(16'h41, 4, 0, "R5 misaligned load");
        do_load(NBYTES + 8, 8, 0, "R5 out of range load");
        do_load(16'h50, 8, 0, "R5 memory unchanged after errors");

        // R2: both request flags high is not accepted
        wait_idle();
        req_ld_i = 1; req_st_i = 1; addr_vld_i = 1; addr_i = 12'h50; len_i = 8;
        @(negedge clk);
        chk(busy_o == 0, "R2 both requests rejected", 64'(busy_o), 0);
        req_ld_i = 0; req_st_i = 0; addr_vld_i = 0;

        // R7: stray store pulse while idle writes nothing
        st_data_i = 64'hFFFF_FFFF_FFFF_FFFF; st_vld_i = 1; addr_i = 12'h50;
        @(negedge clk);
        st_vld_i = 0;
        chk(busy_o == 0, "R7 stray pulse ignored", 64'(busy_o), 0);
        do_load(16'h50, 8, 0, "R7 memory unchanged after stray pulse");

        // R8: privilege bit has no effect
        do_store(16'h60, 4, 64'h5566_7788, 0, 1);
        do_load(16'h60, 4, 0, "R8 priv 0 load");
        do_load(16'h60, 4, 1, "R8 priv 1 load");

        // R6: zero block preserves neighbours
        do_store(16'h78, 8, 64'h0102_0304_0506_0708, 0, 0);
        do_store(16'h80, 8, 64'h1112_1314_1516_1718, 0, 0);
        do_store(16'h98, 8, 64'h2122_2324_2526_2728, 0, 0);
        do_store(16'hA0, 8, 64'h3132_3334_3536_3738, 0, 0);
        do_store(16'h93, 8, 64'h7777, 1, 0);
        do_load(16'h78, 8, 0, "R6 word below block kept");
        do_load(16'h80, 8, 0, "R6 block start zeroed");
        do_load(16'h98, 8, 0, "R6 block end zeroed");
        do_load(16'hA0, 8, 0, "R6 word above block kept");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int sel = $urandom_range(0, 3);
            int lsel = $urandom_range(0, 9);
            int len = (lsel < 2) ? 1 : (lsel < 4) ? 2 : (lsel < 6) ? 4 : (lsel < 9) ? 8 : 3;
            int addr;
            if ($urandom_range(0, 9) == 0) addr = $urandom_range(0, (1 << ADDR_W) - 1);
            else if ($urandom_range(0, 4) == 0) addr = $urandom_range(0, NBYTES - 1);
            else addr = ($urandom_range(0, NBYTES - 1) / len) * len;
            if (sel == 0) do_load(addr, len, 1'($urandom), "R4 random load");
            else if (sel == 1 && $urandom_range(0, 7) == 0)
                do_store(addr, len, {$urandom, $urandom}, 1, 1'($urandom));
            else do_store(addr, len, {$urandom, $urandom}, 0, 1'($urandom));
        end
        for (int w = 0; w < DEPTH; w++) do_load(w * 8, 8, 0, "R3 final memory sweep");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule